// File: doc/BRIEF.md
# Token FIFO Channel Synchronization Controller

This block controls one channel between two tasks that exchange fixed-size token buffers through a circular region of shared memory. A configuration write sets the region's base address, the size of one token, the number of token slots, and the direction of the channel. In input mode the local task consumes tokens. In output mode it produces them. The controller only synchronizes the two sides. It never moves data.

Each side advances only its own committed counter. The counter is an index that runs modulo the slot count, plus a wrap bit, so no atomic read-modify-write is needed. The remote side's committed counter is mirrored into the controller through plain register writes. A private reservation counter runs ahead of the local committed counter. This lets the local task claim several tokens, use them in any order, and then release them in order. After every release the controller emits the new committed counter value, which the peer's mirror then picks up.

Top module: `tok_chan_ctrl`

## Requirements
- R1: After reset, and after any configuration write, all counters, the peer mirror and the error flag are zero. The result outputs are idle in the following cycle. A reset leaves a slot count of 1 and input mode.
- R2: In input mode (`cfg_dir_i`=0), a token is available exactly when the reservation counter differs from the peer mirror in index or wrap bit.
- R3: In output mode (`cfg_dir_i`=1), a slot is available unless the reservation index equals the mirrored index while the wrap bits differ.
- R4: A claim that finds a token raises `tok_vld_o` in the next cycle, with `tok_addr_o` = base + reservation index × token size, and advances the reservation counter. A claim held high delivers one token per cycle. A claim that finds nothing is blocked: it gives no `tok_vld_o` and moves no counter.
- R5: Each counter index runs 0..slots-1. When the index wraps to 0, its wrap bit toggles. The token address returns to the base when the reservation index wraps.
- R6: A query sets `qry_vld_o` in the next cycle, with `qry_avail_o` equal to the availability a claim would have seen. A query changes no state.
- R7: A release, when at least one reserved token is not yet released, advances the committed counter. In the next cycle it pulses `ntf_we_o` with `ntf_cnt_o` = {wrap bit, index} of the new committed counter. Bit CW is the wrap bit.
- R8: A release with no reserved-but-unreleased token sets the sticky `rel_err_o`. It changes no counter and emits no notification. Only reset or a configuration write clears the flag.
- R9: A peer mirror write (`peer_cnt_i`, with the same {wrap, index} layout) takes effect for claims and queries from the next cycle on.
- R10: The same logic serves both directions. Only `cfg_dir_i` selects which availability rule of R2 and R3 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the configuration and clear all channel state |
| cfg_base_i | input | AW | Base address of the token region |
| cfg_tsize_i | input | AW | Bytes per token |
| cfg_max_i | input | CW | Number of token slots; must be nonzero |
| cfg_dir_i | input | 1 | 0 = input (consumer), 1 = output (producer) |
| peer_we_i | input | 1 | Update the peer counter mirror |
| peer_cnt_i | input | CW+1 | Peer committed counter {wrap, index} |
| claim_i | input | 1 | Claim request |
| query_i | input | 1 | Non-blocking availability query |
| release_i | input | 1 | Release the oldest reserved token |
| tok_vld_o | output | 1 | Claim granted; address valid |
| tok_addr_o | output | AW | Address of the granted token |
| qry_vld_o | output | 1 | Query answer valid |
| qry_avail_o | output | 1 | Query answer: token available |
| ntf_we_o | output | 1 | Counter notification write for the peer |
| ntf_cnt_o | output | CW+1 | New committed counter {wrap, index} |
| rel_err_o | output | 1 | Sticky release-without-reservation error |

## Verification
Claims are tried in a blocked burst against an empty mirror, in a held burst that drains a partial mirror, and across an index wrap. Together these separate the per-cycle delivery rate, the blocking point and the address return to the base. Releases are issued up to and one past the reservation, which separates a valid release from a faulty one. The peer mirror is then set to a wrapped value, which shows that the comparison covers the wrap bit and not only the index. Finally, output mode is run with a zero mirror, where a correct design grants at once and then stops after exactly the slot count. This tells the two availability rules apart.

// File: rtl/tok_chan_pkg.sv
package tok_chan_pkg;
  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } chan_dir_e;
endpackage

// File: rtl/wrap_ctr.sv
module wrap_ctr #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] max_i,
  output logic [CW-1:0] idx_o,
  output logic          wrap_o,
  output logic [CW-1:0] nxt_idx_o,
  output logic          nxt_wrap_o
);
  logic [CW-1:0] idx_q;
  logic          wrap_q;

  always_comb begin
    if (idx_q == max_i - CW'(1)) begin
      nxt_idx_o  = '0;
      nxt_wrap_o = ~wrap_q;
    end else begin
      nxt_idx_o  = idx_q + CW'(1);
      nxt_wrap_o = wrap_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr_i) begin
      idx_q  <= '0;
      wrap_q <= 1'b0;
    end else if (inc_i) begin
      idx_q  <= nxt_idx_o;
      wrap_q <= nxt_wrap_o;
    end
  end

  assign idx_o  = idx_q;
  assign wrap_o = wrap_q;

  p_idx_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_i != '0) |-> (idx_o < max_i));
  p_wrap_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && idx_o == max_i - CW'(1)) |=> (idx_o == '0 && wrap_o != $past(wrap_o)));
endmodule

// File: rtl/avail_cmp.sv
module avail_cmp
  import tok_chan_pkg::*;
#(
  parameter int CW = 8
) (
  input  chan_dir_e     dir_i,
  input  logic [CW-1:0] a_idx_i,
  input  logic          a_wrap_i,
  input  logic [CW-1:0] b_idx_i,
  input  logic          b_wrap_i,
  output logic          avail_o
);
  logic same_idx, same_wrap;
  assign same_idx  = (a_idx_i == b_idx_i);
  assign same_wrap = (a_wrap_i == b_wrap_i);

  // input: anything written beyond our reservation; output: ring not full
  always_comb begin
    if (dir_i == DIR_OUT) avail_o = !(same_idx && !same_wrap);
    else                  avail_o = !(same_idx && same_wrap);
  end
endmodule

// File: rtl/tok_addr_gen.sv
module tok_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] tsize_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       off_q <= '0;
    else if (clr_i)    off_q <= '0;
    else if (adv_i)    off_q <= wrap_i ? '0 : off_q + tsize_i;
  end

  assign addr_o = base_i + off_q;

  p_wrap_to_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i && !clr_i) |=> (addr_o == base_i));
endmodule

// File: rtl/tok_chan_ctrl.sv
module tok_chan_ctrl
  import tok_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_tsize_i,
  input  logic [CW-1:0] cfg_max_i,
  input  logic          cfg_dir_i,
  input  logic          peer_we_i,
  input  logic [CW:0]   peer_cnt_i,
  input  logic          claim_i,
  input  logic          query_i,
  input  logic          release_i,
  output logic          tok_vld_o,
  output logic [AW-1:0] tok_addr_o,
  output logic          qry_vld_o,
  output logic          qry_avail_o,
  output logic          ntf_we_o,
  output logic [CW:0]   ntf_cnt_o,
  output logic          rel_err_o
);
  localparam int PW = CW + 1;

  logic [AW-1:0] base_q, tsize_q;
  logic [CW-1:0] max_q;
  chan_dir_e     dir_q;
  logic [PW-1:0] peer_q;

  logic [CW-1:0] rsv_idx, rsv_nidx, com_idx, com_nidx;
  logic          rsv_wrap, rsv_nwrap, com_wrap, com_nwrap;
  logic          tok_avail, held;
  logic          claim_ok, rel_ok, rel_bad;
  logic [AW-1:0] cur_addr;

  assign claim_ok = claim_i && tok_avail && !cfg_we_i;
  assign rel_ok   = release_i && held && !cfg_we_i;
  assign rel_bad  = release_i && !held && !cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      tsize_q <= '0;
      max_q   <= CW'(1);
      dir_q   <= DIR_IN;
    end else if (cfg_we_i) begin
      base_q  <= cfg_base_i;
      tsize_q <= cfg_tsize_i;
      max_q   <= cfg_max_i;
      dir_q   <= chan_dir_e'(cfg_dir_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        peer_q <= '0;
    else if (cfg_we_i)  peer_q <= '0;
    else if (peer_we_i) peer_q <= peer_cnt_i;
  end

  wrap_ctr #(.CW(CW)) u_rsv (
    .clk_i, .rst_ni, .clr_i(cfg_we_i), .inc_i(claim_ok), .max_i(max_q),
    .idx_o(rsv_idx), .wrap_o(rsv_wrap), .nxt_idx_o(rsv_nidx), .nxt_wrap_o(rsv_nwrap)
  );

  wrap_ctr #(.CW(CW)) u_com (
    .clk_i, .rst_ni, .clr_i(cfg_we_i), .inc_i(rel_ok), .max_i(max_q),
    .idx_o(com_idx), .wrap_o(com_wrap), .nxt_idx_o(com_nidx), .nxt_wrap_o(com_nwrap)
  );

  avail_cmp #(.CW(CW)) u_tok_av (
    .dir_i(dir_q), .a_idx_i(rsv_idx), .a_wrap_i(rsv_wrap),
    .b_idx_i(peer_q[CW-1:0]), .b_wrap_i(peer_q[CW]), .avail_o(tok_avail)
  );

  // reserved-but-unreleased exists when committed != reservation
  avail_cmp #(.CW(CW)) u_held (
    .dir_i(DIR_IN), .a_idx_i(com_idx), .a_wrap_i(com_wrap),
    .b_idx_i(rsv_idx), .b_wrap_i(rsv_wrap), .avail_o(held)
  );

  tok_addr_gen #(.AW(AW)) u_addr (
    .clk_i, .rst_ni, .clr_i(cfg_we_i), .adv_i(claim_ok),
    .wrap_i(rsv_nwrap != rsv_wrap), .base_i(base_q), .tsize_i(tsize_q), .addr_o(cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_vld_o   <= 1'b0;
      tok_addr_o  <= '0;
      qry_vld_o   <= 1'b0;
      qry_avail_o <= 1'b0;
      ntf_we_o    <= 1'b0;
      ntf_cnt_o   <= '0;
      rel_err_o   <= 1'b0;
    end else if (cfg_we_i) begin
      tok_vld_o   <= 1'b0;
      qry_vld_o   <= 1'b0;
      ntf_we_o    <= 1'b0;
      rel_err_o   <= 1'b0;
    end else begin
      tok_vld_o <= claim_ok;
      if (claim_ok) tok_addr_o <= cur_addr;
      qry_vld_o   <= query_i;
      qry_avail_o <= tok_avail;
      ntf_we_o    <= rel_ok;
      if (rel_ok) ntf_cnt_o <= {com_nwrap, com_nidx};
      if (rel_bad) rel_err_o <= 1'b1;
    end
  end

  p_tok_needs_claim_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_vld_o |-> $past(claim_i));
  p_blocked_claim_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && !tok_avail && !cfg_we_i) |=> ($stable(rsv_idx) && $stable(rsv_wrap) && !tok_vld_o));
  p_query_answer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qry_vld_o |-> $past(query_i));
  p_notify_after_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_we_o |-> $past(release_i));
  p_bad_release_no_move_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_bad |=> ($stable(com_idx) && $stable(com_wrap) && !ntf_we_o && rel_err_o));
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_err_o && !cfg_we_i) |=> rel_err_o);
  p_cfg_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (!rel_err_o && !tok_vld_o && !ntf_we_o && !qry_vld_o));
endmodule

// File: tb/tok_chan_ctrl_test.sv
module tok_chan_ctrl_test;
  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0, cfg_dir = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_tsize = '0;
  logic [CW-1:0] cfg_max = '0;
  logic          peer_we = 1'b0;
  logic [CW:0]   peer_cnt = '0;
  logic          claim = 1'b0, query = 1'b0, release_r = 1'b0;
  logic          tok_vld, qry_vld, qry_avail, ntf_we, rel_err;
  logic [AW-1:0] tok_addr;
  logic [CW:0]   ntf_cnt;

  always #2 clk = ~clk;

  tok_chan_ctrl #(.AW(AW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_base_i(cfg_base), .cfg_tsize_i(cfg_tsize),
    .cfg_max_i(cfg_max), .cfg_dir_i(cfg_dir),
    .peer_we_i(peer_we), .peer_cnt_i(peer_cnt),
    .claim_i(claim), .query_i(query), .release_i(release_r),
    .tok_vld_o(tok_vld), .tok_addr_o(tok_addr),
    .qry_vld_o(qry_vld), .qry_avail_o(qry_avail),
    .ntf_we_o(ntf_we), .ntf_cnt_o(ntf_cnt), .rel_err_o(rel_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference: linear positions in 0..2*max-1
  int m_max = 1, m_dir = 0;
  longint m_base = 0, m_tsize = 0;
  int m_rsv = 0, m_com = 0, m_peer = 0;
  bit e_tv = 0, e_qv = 0, e_qa = 0, e_nwe = 0, e_err = 0;
  longint e_addr = 0, e_ncnt = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lin_to_cnt(int l);
    return ((l / m_max) << CW) | (l % m_max);
  endfunction

  task automatic model_edge();
    int two, avail, held;
    bit cl, rok;
    if (!rst_ni) begin
      m_max = 1; m_dir = 0; m_base = 0; m_tsize = 0;
      m_rsv = 0; m_com = 0; m_peer = 0;
      e_tv = 0; e_qv = 0; e_qa = 0; e_nwe = 0; e_err = 0; e_addr = 0; e_ncnt = 0;
    end else if (cfg_we) begin
      m_max = int'(cfg_max); m_dir = int'(cfg_dir);
      m_base = longint'(cfg_base); m_tsize = longint'(cfg_tsize);
      m_rsv = 0; m_com = 0; m_peer = 0;
      e_tv = 0; e_qv = 0; e_nwe = 0; e_err = 0;
    end else begin
      two = 2 * m_max;
      if (m_dir == 1) avail = m_max - ((m_rsv - m_peer + two) % two);
      else            avail = (m_peer - m_rsv + two) % two;
      held = (m_rsv - m_com + two) % two;
      e_qv = query; e_qa = (avail > 0);
      cl = claim && (avail > 0);
      e_tv = cl;
      if (cl) begin
        e_addr = (m_base + longint'(m_rsv % m_max) * m_tsize) & 64'hFFFF_FFFF;
        m_rsv = (m_rsv + 1) % two;
      end
      rok = release_r && (held > 0);
      if (release_r && held == 0) e_err = 1;
      e_nwe = rok;
      if (rok) begin
        m_com = (m_com + 1) % two;
        e_ncnt = lin_to_cnt(m_com);
      end
      if (peer_we) m_peer = int'(peer_cnt[CW]) * m_max + int'(peer_cnt[CW-1:0]);
    end
  endtask

  task automatic step();
    string rq;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    rq = (m_dir == 1) ? "R3" : "R2";
    chk(tok_vld == e_tv, rq, "tok_vld", tok_vld, e_tv);
    if (e_tv) chk(tok_addr == e_addr[AW-1:0], "R4", "tok_addr", tok_addr, e_addr);
    chk(qry_vld == e_qv, "R6", "qry_vld", qry_vld, e_qv);
    if (e_qv) chk(qry_avail == e_qa, "R6", "qry_avail", qry_avail, e_qa);
    chk(ntf_we == e_nwe, "R7", "ntf_we", ntf_we, e_nwe);
    if (e_nwe) chk(ntf_cnt == e_ncnt[CW:0], "R7", "ntf_cnt", ntf_cnt, e_ncnt);
    chk(rel_err == e_err, "R8", "rel_err", rel_err, e_err);
  endtask

  task automatic do_cfg(longint b, longint t, int mx, bit d);
    cfg_we = 1; cfg_base = b[AW-1:0]; cfg_tsize = t[AW-1:0]; cfg_max = CW'(mx); cfg_dir = d;
    step();
    cfg_we = 0;
  endtask

  task automatic do_peer(int w, int i);
    peer_we = 1; peer_cnt = {w[0], CW'(i)};
    step();
    peer_we = 0;
  endtask

  initial begin
    int n;
    repeat (2) step();
    rst_ni = 1;
    step();
    chk(!tok_vld && !ntf_we && !rel_err && !qry_vld, "R1", "idle after reset",
        {tok_vld, ntf_we, rel_err, qry_vld}, 0);

    // input mode: 4 slots
    do_cfg(64'h1000, 64'h40, 4, 0);
    claim = 1; query = 1; step();
    chk(!tok_vld, "R2", "claim on empty mirror blocked", tok_vld, 0);
    claim = 0; query = 0; step();

    do_peer(0, 3);
    claim = 1; n = 0;
    for (int k = 0; k < 4; k++) begin
      step();
      if (k == 0) chk(tok_vld, "R9", "mirror used next cycle", tok_vld, 1);
      if (tok_vld) n++;
    end
    claim = 0;
    chk(n == 3, "R4", "tokens in held burst", n, 3);

    release_r = 1;
    repeat (4) step();
    release_r = 0; step();
    chk(rel_err, "R8", "release past reservation flags", rel_err, 1);

    // wrapped mirror: 3 more tokens, reservation crosses index 3 -> 0
    do_peer(1, 2);
    claim = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      if (k == 1) chk(tok_addr == 32'h1000, "R5", "address back at base", tok_addr, 32'h1000);
    end
    claim = 0; query = 1; step();
    query = 0;
    release_r = 1; repeat (3) step();
    release_r = 0; step();

    // output mode: 3 slots, mirror zero means all space free
    do_cfg(64'h2000, 64'h10, 3, 1);
    chk(!rel_err, "R1", "config clears error", rel_err, 0);
    claim = 1; step();
    chk(tok_vld, "R10", "output mode grants with zero mirror", tok_vld, 1);
    repeat (3) step();
    claim = 0; query = 1; step();
    query = 0;
    do_peer(0, 2);
    claim = 1; release_r = 1;
    repeat (3) step();
    claim = 0;
    repeat (3) step();
    release_r = 0;
    repeat (2) step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule